// File: doc/BRIEF.md
# Tag Check Fault Response Controller

This block decides what the core does after a data access reports an allocation-tag mismatch. Each report comes with the faulting address, a load/store flag, a user-level flag, the level that owns the access regime and a two-address-range flag. The block also takes the four control bits that hold the two 2-bit check-fail modes. One mode applies to user-level regimes and the other applies to all other regimes.

The selected mode decides the outcome. The mismatch can be ignored, it can raise a synchronous data-abort request, or it can set a sticky asynchronous fault flag. Each level has its own two-bit flag register. Software reads that register through a level-indexed read port and overwrites it through a level-indexed write port. Exception delivery is done elsewhere: the block drives a one-cycle abort request together with a held address and a held syndrome.

Top module: `tag_fault_ctrl`

## Requirements
- R1: After reset, `sflt_req` is 0, `sflt_addr` is 0, `sflt_syn` is 0 and every level's flag register reads 2'b00.
- R2: When `chk_user` is 1, the mode is `ctl_tcf[1:0]` (control-word bits 39:38) and flags are recorded at level 0. When `chk_user` is 0, the mode is `ctl_tcf[3:2]` (control-word bits 41:40) and flags are recorded at level `chk_lvl`.
- R3: Mode 0 has no effect: no abort request is raised and no flag register changes.
- R4: Mode 1 raises a synchronous abort request for both loads and stores, and sets no flag.
- R5: Mode 2 sets an asynchronous flag and never raises an abort request.
- R6: Mode 3 sets an asynchronous flag for stores (`chk_write`=1) and raises a synchronous abort for loads.
- R7: The flag bit set is `chk_addr[55]` when `chk_two_rng` is 1 and bit 0 otherwise. It is ORed into the level's register.
- R8: An abort request is a one-cycle pulse on `sflt_req` in the cycle after the report. In that cycle `sflt_addr` equals the faulting address, `sflt_syn[5:0]` equals 6'h11 and `sflt_syn[6]` equals `chk_write` (1 = write).
- R9: `sflt_addr` and `sflt_syn` keep their values until the next abort request.
- R10: Flag bits stay set until a write to their level. A write (`aflg_wr_en`) replaces the level's value with `aflg_wr_data`. A flag set in the same cycle is ORed on top of the written value. `aflg_rd_data` shows the register of level `aflg_rd_lvl` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_fail | input | 1 | Tag mismatch report, valid for one cycle |
| chk_addr | input | ADDR_W | Faulting virtual address |
| chk_write | input | 1 | 1 = store, 0 = load |
| chk_user | input | 1 | Access uses a user-level regime |
| chk_lvl | input | LVL_W | Level owning the regime (used when not user) |
| chk_two_rng | input | 1 | Regime has two address ranges |
| ctl_tcf | input | 4 | Control-word bits 41:38: [1:0] user mode, [3:2] other mode |
| sflt_req | output | 1 | Synchronous abort request pulse |
| sflt_addr | output | ADDR_W | Address reported with the abort |
| sflt_syn | output | 7 | [5:0] fault status 0x11, [6] write-not-read |
| aflg_rd_lvl | input | LVL_W | Flag register read index |
| aflg_rd_data | output | 2 | Flag register of the indexed level |
| aflg_wr_en | input | 1 | Flag register write strobe |
| aflg_wr_lvl | input | LVL_W | Flag register write index |
| aflg_wr_data | input | 2 | Flag register write value |

## Verification
The bench sweeps every mode against both directions, both privilege classes, every level, both range settings and both values of address bit 55. The control field that is not selected always holds the complement of the selected one, so a design that read the wrong field would raise or suppress the wrong action. After each report the bench reads back all four levels. This exposes a flag written to the wrong level, a mode-0 report that leaves a trace, and a bit index taken from bit 55 when only one address range exists. Directed cases cover the rest: two faults accumulating at one level, a software write that replaces the value, a fault arriving in the same cycle as a clearing write (the fault must survive), and the abort address staying frozen while async-only faults follow.

// File: rtl/tag_fault_ctrl.sv
module tag_fault_ctrl #(
  parameter int ADDR_W = 64,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_fail,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              chk_write,
  input  logic              chk_user,
  input  logic [LVL_W-1:0]  chk_lvl,
  input  logic              chk_two_rng,
  input  logic [3:0]        ctl_tcf,
  output logic              sflt_req,
  output logic [ADDR_W-1:0] sflt_addr,
  output logic [6:0]        sflt_syn,
  input  logic [LVL_W-1:0]  aflg_rd_lvl,
  output logic [1:0]        aflg_rd_data,
  input  logic              aflg_wr_en,
  input  logic [LVL_W-1:0]  aflg_wr_lvl,
  input  logic [1:0]        aflg_wr_data
);
  localparam int SEL_BIT = 55;
  localparam logic [5:0] FSC = 6'h11;

  logic [1:0] mode;
  logic [LVL_W-1:0] tgt;
  logic go_sync, go_async;
  logic [1:0] set_mask;
  logic [LEVELS-1:0][1:0] flg_q;

  assign mode     = chk_user ? ctl_tcf[1:0] : ctl_tcf[3:2];
  assign tgt      = chk_user ? '0 : chk_lvl;
  assign go_sync  = chk_fail && (mode == 2'd1 || (mode == 2'd3 && !chk_write));
  assign go_async = chk_fail && (mode == 2'd2 || (mode == 2'd3 && chk_write));
  assign set_mask = (chk_two_rng && chk_addr[SEL_BIT]) ? 2'b10 : 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sflt_req  <= 1'b0;
      sflt_addr <= '0;
      sflt_syn  <= '0;
    end else begin
      sflt_req <= go_sync;
      if (go_sync) begin
        sflt_addr <= chk_addr;
        sflt_syn  <= {chk_write, FSC};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else begin
      for (int l = 0; l < LEVELS; l++) begin
        flg_q[l] <= ((aflg_wr_en && aflg_wr_lvl == LVL_W'(l)) ? aflg_wr_data : flg_q[l])
                  | ((go_async && tgt == LVL_W'(l)) ? set_mask : 2'b00);
      end
    end
  end

  assign aflg_rd_data = flg_q[aflg_rd_lvl];
endmodule

// File: rtl/tag_fault_ctrl_chk.sv
module tag_fault_ctrl_chk #(
  parameter int ADDR_W = 64,
  parameter int LEVELS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  chk_fail,
  input logic                  chk_write,
  input logic                  chk_user,
  input logic [3:0]            ctl_tcf,
  input logic                  aflg_wr_en,
  input logic                  sflt_req,
  input logic [ADDR_W-1:0]     sflt_addr,
  input logic [6:0]            sflt_syn,
  input logic [2*LEVELS-1:0]   flg
);
  logic [1:0] m;
  assign m = chk_user ? ctl_tcf[1:0] : ctl_tcf[3:2];

  AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fail && m == 2'd0 && !aflg_wr_en) |=> (!sflt_req && flg == $past(flg))); // R3
  AST_MODE1_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fail && m == 2'd1) |=> sflt_req); // R4
  AST_MODE2_NOABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fail && m == 2'd2) |=> !sflt_req); // R5
  AST_MODE3_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fail && m == 2'd3) |=> (sflt_req == !$past(chk_write))); // R6
  AST_SYN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    sflt_req |-> (sflt_syn[5:0] == 6'h11 && sflt_syn[6] == $past(chk_write))); // R8
  AST_REPORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sflt_req |-> ($stable(sflt_addr) && $stable(sflt_syn))); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !aflg_wr_en |=> ((~flg & $past(flg)) == '0)); // R10
endmodule

bind tag_fault_ctrl tag_fault_ctrl_chk #(.ADDR_W(ADDR_W), .LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_fail(chk_fail), .chk_write(chk_write),
  .chk_user(chk_user), .ctl_tcf(ctl_tcf), .aflg_wr_en(aflg_wr_en),
  .sflt_req(sflt_req), .sflt_addr(sflt_addr), .sflt_syn(sflt_syn), .flg(flg_q)
);

// File: tb/tb_tag_fault_ctrl.sv
module tb_tag_fault_ctrl;
  localparam int ADDR_W = 64;
  localparam int LEVELS = 4;
  localparam int LVL_W = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic chk_fail = 0;
  logic [ADDR_W-1:0] chk_addr = '0;
  logic chk_write = 0, chk_user = 0, chk_two_rng = 0;
  logic [LVL_W-1:0] chk_lvl = '0;
  logic [3:0] ctl_tcf = '0;
  logic sflt_req;
  logic [ADDR_W-1:0] sflt_addr;
  logic [6:0] sflt_syn;
  logic [LVL_W-1:0] aflg_rd_lvl = '0;
  logic [1:0] aflg_rd_data;
  logic aflg_wr_en = 0;
  logic [LVL_W-1:0] aflg_wr_lvl = '0;
  logic [1:0] aflg_wr_data = '0;

  int total = 0, bad = 0;
  bit done = 0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic [6:0] last_syn = '0;

  always #10 clk = ~clk;

  tag_fault_ctrl #(.ADDR_W(ADDR_W), .LEVELS(LEVELS)) dut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic read_flag(input int l, output logic [1:0] v);
    aflg_rd_lvl = LVL_W'(l);
    #1 v = aflg_rd_data;
  endtask

  task automatic write_flag(input int l, input logic [1:0] d);
    @(negedge clk);
    aflg_wr_en = 1; aflg_wr_lvl = LVL_W'(l); aflg_wr_data = d;
    @(negedge clk);
    aflg_wr_en = 0;
  endtask

  task automatic run_case(input int m, input bit usr, input bit wr, input bit two,
                          input bit a55, input int lvl, input int idx);
    logic [1:0] v, expf;
    bit esync, easync;
    int tgt, sel;
    for (int l = 0; l < LEVELS; l++) write_flag(l, 2'b00);
    esync  = (m == 1) || (m == 3 && !wr);
    easync = (m == 2) || (m == 3 && wr);
    tgt = usr ? 0 : lvl;
    sel = (two && a55) ? 1 : 0;
    chk_addr = {8'h3C, a55, 39'h0, 16'(idx * 16 + 5)};
    chk_write = wr; chk_user = usr; chk_two_rng = two; chk_lvl = LVL_W'(lvl);
    ctl_tcf = usr ? {~2'(m), 2'(m)} : {2'(m), ~2'(m)};
    chk_fail = 1;
    @(negedge clk);
    chk_fail = 0;
    if (m == 0) check(sflt_req == 0, "R3 mode0 no abort", 64'(sflt_req), 0);
    else if (m == 1) check(sflt_req == 1, "R4 mode1 abort", 64'(sflt_req), 1);
    else if (m == 2) check(sflt_req == 0, "R5 mode2 no abort", 64'(sflt_req), 0);
    else check(sflt_req == esync, "R6 mode3 split", 64'(sflt_req), 64'(esync));
    if (esync) begin
      last_addr = chk_addr;
      last_syn = {wr, 6'h11};
      check(sflt_addr == last_addr, "R8 abort address", sflt_addr, last_addr);
      check(sflt_syn == last_syn, "R8 syndrome", 64'(sflt_syn), 64'(last_syn));
    end else begin
      check(sflt_addr == last_addr && sflt_syn == last_syn, "R9 report held",
            sflt_addr, last_addr);
    end
    for (int l = 0; l < LEVELS; l++) begin
      read_flag(l, v);
      expf = (easync && l == tgt) ? (2'b01 << sel) : 2'b00;
      if (m == 0) check(v == expf, "R3 mode0 flags untouched", 64'(v), 64'(expf));
      else if (usr) check(v == expf, "R2 user flag level", 64'(v), 64'(expf));
      else check(v == expf, "R7 flag bit and level", 64'(v), 64'(expf));
    end
    @(negedge clk);
    check(sflt_req == 0, "R8 single-cycle pulse", 64'(sflt_req), 0);
  endtask

  initial begin
    logic [1:0] v;
    int idx;
    idx = 0;
    #35;
    check(sflt_req == 0 && sflt_addr == 0 && sflt_syn == 0, "R1 reset outputs", sflt_addr, 0);
    for (int l = 0; l < LEVELS; l++) begin
      read_flag(l, v);
      check(v == 0, "R1 reset flags", 64'(v), 0);
    end
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      for (int u = 0; u < 2; u++)
        for (int w = 0; w < 2; w++)
          for (int t = 0; t < 2; t++)
            for (int a = 0; a < 2; a++)
              for (int l = 0; l < (u ? 1 : LEVELS); l++) begin
                run_case(m, u[0], w[0], t[0], a[0], l, idx);
                idx++;
              end

    for (int l = 0; l < LEVELS; l++) write_flag(l, 2'b00);
    chk_user = 0; chk_lvl = 2; chk_write = 1; chk_two_rng = 1; ctl_tcf = 4'b1000;
    chk_addr = 64'h0080_0000_0000_0040; chk_fail = 1;
    @(negedge clk);
    chk_addr = 64'h0000_0000_0000_0080;
    @(negedge clk);
    chk_fail = 0;
    read_flag(2, v);
    check(v == 2'b11, "R10 sticky accumulation", 64'(v), 3);
    check(sflt_addr == last_addr, "R9 held across async faults", sflt_addr, last_addr);
    write_flag(2, 2'b01);
    read_flag(2, v);
    check(v == 2'b01, "R10 write replaces", 64'(v), 1);
    @(negedge clk);
    aflg_wr_en = 1; aflg_wr_lvl = 2; aflg_wr_data = 2'b00;
    chk_addr = 64'h0080_0000_0000_0100; chk_fail = 1;
    @(negedge clk);
    aflg_wr_en = 0; chk_fail = 0;
    read_flag(2, v);
    check(v == 2'b10, "R10 set wins over same-cycle write", 64'(v), 2);
    @(negedge clk);
    @(negedge clk);
    read_flag(2, v);
    check(v == 2'b10, "R10 flag stays set", 64'(v), 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule